// File: doc/BRIEF.md
# Dual-Enable Asynchronous ROM Read Sequencer

This block sits between a synchronous host and an asynchronous parallel read-only memory that has two active-low control lines: a chip select that powers the device up, and an output gate that lets it drive the data pins. The host offers a word address with a valid/ready handshake. The sequencer latches the address, pulls chip select low on the same edge, and opens the output gate later. It samples the data only after three delays have all run out: the delay from the address, the delay from chip select and the delay from the output gate.

The output gate is opened as late as possible without making the read any longer. That point is the longer of the address and chip-select delays, minus the gate delay. Both enables are released on the same edge that captures the data, because the memory keeps its outputs for zero time after a control change. The sequencer then waits out the memory's output turn-off time before it accepts another request. While it is idle, chip select stays high, so the memory is in standby.

Each delay is given in picoseconds together with the clock period, and is converted to clock cycles by rounding up. With the default values (8 ns clock, 55 ns address delay, 55 ns chip-select delay, 40 ns gate delay, 30 ns turn-off time) the counts are 7, 7, 5 and 4 cycles.

Top module: `rom_rd_ctrl`

## Requirements
- R1: While reset is asserted and just after it: rom_ce_n_o=1, rom_oe_n_o=1, rsp_valid_o=0 and req_ready_o=1.
- R2: req_ready_o is high only when no read is in progress. It goes low on the edge that accepts a request (req_valid_i=1 and req_ready_o=1). It comes back high FLOAT cycles after the capture edge, where FLOAT is the turn-off time in cycles.
- R3: On the accepting edge, rom_addr_o takes the value of req_addr_i and rom_ce_n_o goes low. Both hold until the capture edge.
- R4: rom_oe_n_o goes low OE_LAG cycles after the accepting edge. OE_LAG = max(ADDR, CE) - OE, with a floor of zero. ADDR, CE and OE are the address, chip-select and gate delays in cycles.
- R5: Data is captured SAMPLE cycles after the accepting edge, where SAMPLE = max(ADDR, CE, OE). rsp_valid_o is high for exactly that one cycle, and rsp_data_o holds the word that rom_dq_i carried at the capture edge.
- R6: rom_ce_n_o and rom_oe_n_o both return high on the capture edge.
- R7: rom_ce_n_o is high whenever the block is idle or in the turn-off wait. rom_oe_n_o is never low while rom_ce_n_o is high.
- R8: Each delay in cycles is the delay in picoseconds divided by the clock period, rounded up (55 ns at 8 ns gives 7 cycles, 40 ns gives 5 cycles, 30 ns gives 4 cycles).
- R9: Changes on req_addr_i and req_valid_i while a read is in progress have no effect on rom_addr_o or on the read timing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid_i | input | 1 | Host read request valid |
| req_ready_o | output | 1 | Sequencer can accept a request |
| req_addr_i | input | ADDR_W | Word address of the request |
| rsp_valid_o | output | 1 | One-cycle pulse marking captured data |
| rsp_data_o | output | DATA_W | Captured read word |
| rom_addr_o | output | ADDR_W | Address pins to the memory |
| rom_ce_n_o | output | 1 | Active-low chip select |
| rom_oe_n_o | output | 1 | Active-low output gate |
| rom_dq_i | input | DATA_W | Data pins from the memory |

## Verification
The memory model in the bench drives the correct word only once all three delays have elapsed; before that it drives the inverted word. A capture made even one cycle early is therefore seen as wrong data, not just as a timing slip. Random addresses and random idle gaps are mixed with back-to-back requests that hold valid high. This separates a correct turn-off wait from one that lets the next chip-select fall too early. The all-zero and all-one addresses and a repeated address catch latching faults. While a read is in progress, the bench scrambles the host address to show that the pins do not follow it.

// File: rtl/rom_rd_pkg.sv
package rom_rd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SETUP = 2'd1,
    ST_DRIVE = 2'd2,
    ST_FLOAT = 2'd3
  } rd_state_t;

  // Cycles needed to cover t_ps at period clk_ps: rounded up, never below one.
  function automatic int unsigned ps_to_cyc(input int unsigned t_ps, input int unsigned clk_ps);
    int unsigned c;
    c = (t_ps + clk_ps - 1) / clk_ps;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned max2(input int unsigned a, input int unsigned b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rom_rd_timer.sv
module rom_rd_timer #(
  parameter int unsigned CNT_W = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] val_i,
  output logic             expire_o
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = load_i || (cnt_q != '0);
    cnt_d  = load_i ? val_i : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)      cnt_q <= '0;
    else if (cnt_en)  cnt_q <= cnt_d;
  end

  assign expire_o = (cnt_q == CNT_W'(1));

  // R5: a running window shortens by exactly one each cycle
  a_r5_count_down: assert property (@(posedge clk) disable iff (!arst_n)
    (!load_i && cnt_q > CNT_W'(1)) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/rom_rd_seq.sv
module rom_rd_seq
  import rom_rd_pkg::*;
#(
  parameter int unsigned CNT_W    = 4,
  parameter int unsigned OE_LAG   = 2,
  parameter int unsigned OPEN_CYC = 5,
  parameter int unsigned FLT_CYC  = 4
) (
  input  logic             clk,
  input  logic             arst_n,
  input  logic             fire_i,
  input  logic             expire_i,
  output logic             idle_o,
  output logic             load_o,
  output logic [CNT_W-1:0] load_val_o,
  output logic             capture_o,
  output logic             ce_n_o,
  output logic             oe_n_o
);

  rd_state_t state_q, state_d;
  logic      ce_n_q, ce_n_d;
  logic      oe_n_q, oe_n_d;

  always_comb begin
    state_d    = state_q;
    load_o     = 1'b0;
    load_val_o = '0;
    capture_o  = 1'b0;
    unique case (state_q)
      ST_IDLE: if (fire_i) begin
        load_o = 1'b1;
        if (OE_LAG > 0) begin
          state_d    = ST_SETUP;
          load_val_o = CNT_W'(OE_LAG);
        end else begin
          state_d    = ST_DRIVE;
          load_val_o = CNT_W'(OPEN_CYC);
        end
      end
      ST_SETUP: if (expire_i) begin
        state_d    = ST_DRIVE;
        load_o     = 1'b1;
        load_val_o = CNT_W'(OPEN_CYC);
      end
      ST_DRIVE: if (expire_i) begin
        state_d    = ST_FLOAT;
        load_o     = 1'b1;
        load_val_o = CNT_W'(FLT_CYC);
        capture_o  = 1'b1;
      end
      ST_FLOAT: if (expire_i) state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
    ce_n_d = !((state_d == ST_SETUP) || (state_d == ST_DRIVE));
    oe_n_d = !(state_d == ST_DRIVE);
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      state_q <= ST_IDLE;
      ce_n_q  <= 1'b1;
      oe_n_q  <= 1'b1;
    end else begin
      state_q <= state_d;
      ce_n_q  <= ce_n_d;
      oe_n_q  <= oe_n_d;
    end
  end

  assign idle_o = (state_q == ST_IDLE);
  assign ce_n_o = ce_n_q;
  assign oe_n_o = oe_n_q;

  // R7: gate never open without chip select
  a_r7_gate_needs_select: assert property (@(posedge clk) disable iff (!arst_n)
    !oe_n_q |-> !ce_n_q);

  // R7: standby held through the turn-off wait and idle
  a_r7_standby_when_quiet: assert property (@(posedge clk) disable iff (!arst_n)
    (state_q == ST_FLOAT || state_q == ST_IDLE) |-> ce_n_q);

  // R6: capture releases both enables on the next edge
  a_r6_release_on_capture: assert property (@(posedge clk) disable iff (!arst_n)
    capture_o |=> (ce_n_q && oe_n_q));

endmodule

// File: rtl/rom_rd_datapath.sv
module rom_rd_datapath #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              arst_n,
  input  logic              fire_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              capture_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o
);

  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] data_q;
  logic              vld_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n)     addr_q <= '0;
    else if (fire_i) addr_q <= addr_i;
  end

  always_ff @(posedge clk) begin
    if (capture_i) data_q <= dq_i;
  end

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) vld_q <= 1'b0;
    else         vld_q <= capture_i;
  end

  assign rom_addr_o  = addr_q;
  assign rsp_valid_o = vld_q;
  assign rsp_data_o  = data_q;

  // R5: response is a single-cycle pulse
  a_r5_single_pulse: assert property (@(posedge clk) disable iff (!arst_n)
    vld_q |=> !vld_q);

endmodule

// File: rtl/rom_rd_ctrl.sv
module rom_rd_ctrl
  import rom_rd_pkg::*;
#(
  parameter int unsigned ADDR_W     = 16,
  parameter int unsigned DATA_W     = 16,
  parameter int unsigned CLK_PS     = 8000,
  parameter int unsigned T_ADDR_PS  = 55000,
  parameter int unsigned T_CE_PS    = 55000,
  parameter int unsigned T_OE_PS    = 40000,
  parameter int unsigned T_FLOAT_PS = 30000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid_i,
  output logic              req_ready_o,
  input  logic [ADDR_W-1:0] req_addr_i,
  output logic              rsp_valid_o,
  output logic [DATA_W-1:0] rsp_data_o,
  output logic [ADDR_W-1:0] rom_addr_o,
  output logic              rom_ce_n_o,
  output logic              rom_oe_n_o,
  input  logic [DATA_W-1:0] rom_dq_i
);

  // R8: delays rounded up to whole cycles
  localparam int unsigned ADDR_CYC   = ps_to_cyc(T_ADDR_PS, CLK_PS);
  localparam int unsigned CE_CYC     = ps_to_cyc(T_CE_PS, CLK_PS);
  localparam int unsigned OE_CYC     = ps_to_cyc(T_OE_PS, CLK_PS);
  localparam int unsigned FLT_CYC    = ps_to_cyc(T_FLOAT_PS, CLK_PS);
  localparam int unsigned LEAD_CYC   = max2(ADDR_CYC, CE_CYC);
  localparam int unsigned OE_LAG     = (LEAD_CYC > OE_CYC) ? LEAD_CYC - OE_CYC : 0;
  localparam int unsigned SAMPLE_CYC = max2(LEAD_CYC, OE_CYC);
  localparam int unsigned OPEN_CYC   = SAMPLE_CYC - OE_LAG;
  localparam int unsigned CNT_W      = $clog2(max2(SAMPLE_CYC, FLT_CYC) + 1);

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       arst_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign arst_n = rst_sync_q[1];

  logic             idle;
  logic             fire;
  logic             expire;
  logic             tmr_load;
  logic [CNT_W-1:0] tmr_val;
  logic             capture;

  assign req_ready_o = idle;
  assign fire        = req_valid_i && idle;

  rom_rd_seq #(
    .CNT_W   (CNT_W),
    .OE_LAG  (OE_LAG),
    .OPEN_CYC(OPEN_CYC),
    .FLT_CYC (FLT_CYC)
  ) i_seq (
    .clk       (clk),
    .arst_n    (arst_n),
    .fire_i    (fire),
    .expire_i  (expire),
    .idle_o    (idle),
    .load_o    (tmr_load),
    .load_val_o(tmr_val),
    .capture_o (capture),
    .ce_n_o    (rom_ce_n_o),
    .oe_n_o    (rom_oe_n_o)
  );

  rom_rd_timer #(
    .CNT_W(CNT_W)
  ) i_timer (
    .clk     (clk),
    .arst_n  (arst_n),
    .load_i  (tmr_load),
    .val_i   (tmr_val),
    .expire_o(expire)
  );

  rom_rd_datapath #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_dp (
    .clk        (clk),
    .arst_n     (arst_n),
    .fire_i     (fire),
    .addr_i     (req_addr_i),
    .capture_i  (capture),
    .dq_i       (rom_dq_i),
    .rom_addr_o (rom_addr_o),
    .rsp_valid_o(rsp_valid_o),
    .rsp_data_o (rsp_data_o)
  );

  // R3: accepted request selects the device on the next edge
  a_r3_select_on_accept: assert property (@(posedge clk) disable iff (!arst_n)
    (req_valid_i && req_ready_o) |=> !rom_ce_n_o);

  // R9: pins do not follow the host while busy
  a_r9_addr_held_busy: assert property (@(posedge clk) disable iff (!arst_n)
    !req_ready_o |=> $stable(rom_addr_o));

  // R2: no response while the sequencer reports idle
  a_r2_busy_at_response: assert property (@(posedge clk) disable iff (!arst_n)
    rsp_valid_o |-> !req_ready_o);

endmodule

// File: tb/test_rom_rd_ctrl.sv
`timescale 1ns/1ps
module test_rom_rd_ctrl;

  localparam int AW = 16;
  localparam int DW = 16;
  localparam real TCLK = 8.0;
  localparam real T_A = 55.0, T_C = 55.0, T_O = 40.0, T_F = 30.0;

  // R8: ceil of delay over clock period
  function automatic int cyc_of(input real t);
    int c;
    c = int'($ceil(t / TCLK));
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [DW-1:0] rom_word(input logic [AW-1:0] a);
    logic [31:0] p;
    p = {16'h0, a} * 32'h9E37 ^ 32'h1234;
    return p[DW-1:0];
  endfunction

  int C_A, C_C, C_O, C_F, LEAD, LAG, SAMP;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          req_valid = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic          req_ready, rsp_valid, ce_n, oe_n;
  logic [DW-1:0] rsp_data, rom_dq;
  logic [AW-1:0] rom_addr;

  rom_rd_ctrl i_rom_rd_ctrl (
    .clk(clk), .rst_n(rst_n),
    .req_valid_i(req_valid), .req_ready_o(req_ready), .req_addr_i(req_addr),
    .rsp_valid_o(rsp_valid), .rsp_data_o(rsp_data),
    .rom_addr_o(rom_addr), .rom_ce_n_o(ce_n), .rom_oe_n_o(oe_n),
    .rom_dq_i(rom_dq)
  );

  always #4 clk = ~clk;

  int total = 0, bad = 0, cyc = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s cyc=%0d actual=%0h expected=%0h", req, cyc, act, exp);
    end
  endtask

  // memory model: correct word only when every delay is met by the next edge
  realtime t_a = 0, t_c = 0, t_o = 0;
  always @(rom_addr) t_a = $realtime;
  always @(negedge ce_n) t_c = $realtime;
  always @(negedge oe_n) t_o = $realtime;

  always @(negedge clk) begin
    realtime nxt;
    nxt = $realtime + TCLK / 2.0;
    if (!ce_n && !oe_n && (nxt - t_a >= T_A) && (nxt - t_c >= T_C) && (nxt - t_o >= T_O))
      rom_dq = rom_word(rom_addr);
    else
      rom_dq = ~rom_word(rom_addr);
  end

  always @(posedge clk) cyc <= cyc + 1;

  // monitor
  bit            active = 1'b0;
  int            acc = 0;
  logic [AW-1:0] exp_addr = '0;

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(ce_n === 1'b1 && oe_n === 1'b1, "R1 enables", {ce_n, oe_n}, 2'b11);
      chk(rsp_valid === 1'b0 && req_ready === 1'b1, "R1 handshake", {rsp_valid, req_ready}, 2'b01);
    end else begin
      if (active) begin
        int rel;
        rel = cyc - acc;
        if (rel < LAG)
          chk(ce_n === 1'b0 && oe_n === 1'b1, "R4 setup phase", {ce_n, oe_n}, 2'b01);
        else if (rel < SAMP)
          chk(ce_n === 1'b0 && oe_n === 1'b0, "R4 gate open", {ce_n, oe_n}, 2'b00);
        else
          chk(ce_n === 1'b1 && oe_n === 1'b1, "R6/R7 released", {ce_n, oe_n}, 2'b11);
        if (rel <= SAMP)
          chk(rom_addr === exp_addr, "R3/R9 address held", rom_addr, exp_addr);
        if (rel == SAMP) begin
          chk(rsp_valid === 1'b1, "R5 capture pulse", rsp_valid, 1);
          chk(rsp_data === rom_word(exp_addr), "R5 data", rsp_data, rom_word(exp_addr));
        end else
          chk(rsp_valid === 1'b0, "R5 pulse width", rsp_valid, 0);
        if (rel < SAMP + C_F)
          chk(req_ready === 1'b0, "R2 busy", req_ready, 0);
        else begin
          chk(req_ready === 1'b1, "R2 ready after turn-off", req_ready, 1);
          active = 1'b0;
        end
      end else begin
        chk(ce_n === 1'b1 && oe_n === 1'b1 && rsp_valid === 1'b0, "R7 idle standby",
            {rsp_valid, ce_n, oe_n}, 3'b011);
        chk(req_ready === 1'b1, "R2 idle ready", req_ready, 1);
      end
      if (req_valid && req_ready) begin
        active   = 1'b1;
        acc      = cyc + 1;
        exp_addr = req_addr;
      end
    end
  end

  task automatic do_read(input logic [AW-1:0] a, input int gap);
    for (int i = 0; i < gap; i++) @(posedge clk);
    #1;
    req_valid = 1'b1;
    req_addr  = a;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk);
    #1;
    req_valid = 1'b0;
    req_addr  = AW'($urandom);   // R9: scrambled while busy
  endtask

  task automatic drain;
    @(negedge clk);
    while (active) @(negedge clk);
  endtask

  initial begin
    void'($urandom(32'd4242));
    C_A = cyc_of(T_A); C_C = cyc_of(T_C); C_O = cyc_of(T_O); C_F = cyc_of(T_F);
    LEAD = (C_A > C_C) ? C_A : C_C;
    LAG  = (LEAD > C_O) ? LEAD - C_O : 0;
    SAMP = (LEAD > C_O) ? LEAD : C_O;
    // R8: expected cycle counts for the default timing
    chk(C_A == 7 && C_O == 5 && C_F == 4, "R8 rounding", {C_A[7:0], C_O[7:0], C_F[7:0]}, 24'h070504);
    repeat (5) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (4) @(posedge clk);
    // directed corners
    do_read('0, 0);
    do_read('1, 0);
    do_read(16'h1234, 0);
    do_read(16'h1234, 0);
    drain();
    do_read(16'h8001, 3);
    // random traffic
    for (int n = 0; n < 300; n++) begin
      if ($urandom_range(0, 3) == 0) begin
        #1 req_valid = 1'b0;
      end
      do_read(AW'($urandom), int'($urandom_range(0, 4)));
    end
    drain();
    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog cyc=%0d actual=running expected=finished", cyc);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule